// File: doc/BRIEF.md
# Operand-Waiting Reservation Station

This block sits between the dispatcher and one execution unit. An instruction whose source operands are not all available is parked here. Its destination rename tag is already allocated when it arrives. Every cycle the station compares the result tag on the broadcast bus against each waiting source. When a compare hits, the broadcast value is steered straight to the unit, so the instruction issues in the same cycle in which its last operand is written. The held copy is used only if issue has to wait.

An instruction that arrives with every operand available goes straight to the unit when the unit can accept it and no parked instruction is ready. Otherwise it is parked. The depth is a parameter. A depth of one suits integer, floating-point and system-register units. A depth of two suits the load/store unit. In that case the entries form an age-ordered queue: slot 0 is the oldest, and the oldest ready entry issues first.

Occupancy is a state machine with the states EMPTY, PART (used only when the depth is two) and FULL. Its transitions are STAY (no change), PARK (an entry is added), DRAIN (a parked entry issues), SWAP (one entry issues while another is parked in the same cycle) and CLEAR (flush).

Top module: `rs_station`

## Requirements
- R1: After reset the station is EMPTY, `iss_valid` is 0 and `full` is 0.
- R2: An accepted dispatch with any source still missing after the same-cycle broadcast compare is parked, and nothing issues for it in that cycle. An accepted dispatch is also parked when it cannot bypass (R5).
- R3: A broadcast whose tag equals the tag of a waiting source makes that source ready. If that completes the instruction, it issues in the same cycle, with the broadcast value on that source's lane. A broadcast with a non-matching tag changes nothing. Source s uses bits [s*DATA_W +: DATA_W] of a value bus and bits [s*TAG_W +: TAG_W] of a tag bus. A bit of `disp_rdy` set to 1 means that source is available.
- R4: A source that is already available ignores broadcasts, even ones carrying its tag, and keeps its captured value.
- R5: A dispatch with all sources available issues in its own cycle, without being parked, when `unit_ready` is 1 and no parked entry is ready.
- R6: Nothing issues while `unit_ready` is 0. Ready entries stay held until it returns to 1.
- R7: With a depth of two, when several parked entries are ready the one dispatched first issues. A younger ready entry may issue ahead of an older entry that is still waiting.
- R8: `full` is 1 exactly when every slot is occupied and no parked entry issues in that cycle. A dispatch is ignored while `full` is 1. When one slot issues in the same cycle, the dispatch is accepted into the freed slot.
- R9: `flush` empties the station by the next cycle. In the flush cycle it blocks any issue and any dispatch.
- R10: A broadcast in the cycle of a dispatch is matched against the incoming sources. A matching source is captured with the broadcast value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard all parked instructions |
| disp_valid | input | 1 | Dispatch request |
| disp_rdy | input | NSRC | Per-source availability at dispatch |
| disp_tag | input | NSRC*TAG_W | Producer tags of the sources |
| disp_val | input | NSRC*DATA_W | Captured values of the available sources |
| disp_dst | input | TAG_W | Destination rename tag carried along |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Rename tag being written |
| bc_val | input | DATA_W | Value being written |
| unit_ready | input | 1 | Execution unit can accept an instruction |
| iss_valid | output | 1 | Instruction issued to the unit this cycle |
| iss_val | output | NSRC*DATA_W | Operand values of the issued instruction |
| iss_dst | output | TAG_W | Destination tag of the issued instruction |
| full | output | 1 | No slot can take a dispatch this cycle |

## Verification
Wakeup and issue fall in the same cycle: the bench drives the resolving broadcast, then samples `iss_valid` and the operand lanes before the next edge. It expects the broadcast value on the woken lane and the old captured value on the other lane. Draining and dispatch also meet in one cycle. The bench fills both slots while the unit is stalled, then releases the unit while presenting a new dispatch. It expects `full` low, the oldest entry at the output, and the new entry issuing later after its own broadcast. A flush cycle that also carries a broadcast and a dispatch must yield no issue in that cycle or the next.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_e;

    function automatic int occ_count(occ_e s, int depth);
        int n;
        unique case (s)
            OCC_EMPTY: n = 0;
            OCC_PART:  n = 1;
            OCC_FULL:  n = depth;
            default:   n = 0;
        endcase
        return n;
    endfunction

    function automatic occ_e occ_state(int n, int depth);
        occ_e s;
        if (n <= 0)
            s = OCC_EMPTY;
        else if (n >= depth)
            s = OCC_FULL;
        else
            s = OCC_PART;
        return s;
    endfunction

endpackage

// File: rtl/rs_wakeup.sv
module rs_wakeup #(
    parameter int NSRC   = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic [NSRC-1:0]        rdy_i,
    input  logic [NSRC*TAG_W-1:0]  tag_i,
    input  logic [NSRC*DATA_W-1:0] val_i,
    input  logic                   bc_valid,
    input  logic [TAG_W-1:0]       bc_tag,
    input  logic [DATA_W-1:0]      bc_val,
    output logic [NSRC-1:0]        rdy_o,
    output logic [NSRC*DATA_W-1:0] val_o,
    output logic                   all_o
);
    logic [NSRC-1:0] hit;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        // only sources still waiting listen to the bus (R4)
        assign hit[s] = bc_valid && !rdy_i[s] &&
                        (tag_i[s*TAG_W +: TAG_W] == bc_tag);
        assign rdy_o[s] = rdy_i[s] | hit[s];
        assign val_o[s*DATA_W +: DATA_W] = hit[s] ? bc_val
                                                  : val_i[s*DATA_W +: DATA_W];
    end

    assign all_o = &rdy_o;

endmodule

// File: rtl/rs_oldest.sv
module rs_oldest #(
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] req,
    output logic [DEPTH-1:0] gnt,
    output logic             any
);
    logic found;

    always_comb begin
        gnt   = '0;
        found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assign any = |req;

    // slot 0 holds the oldest entry; a ready oldest entry always wins
    assert_oldest_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> gnt[0]);

    assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int DEPTH  = 2,
    parameter int NSRC   = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   disp_valid,
    input  logic [NSRC-1:0]        disp_rdy,
    input  logic [NSRC*TAG_W-1:0]  disp_tag,
    input  logic [NSRC*DATA_W-1:0] disp_val,
    input  logic [TAG_W-1:0]       disp_dst,
    input  logic                   bc_valid,
    input  logic [TAG_W-1:0]       bc_tag,
    input  logic [DATA_W-1:0]      bc_val,
    input  logic                   unit_ready,
    output logic                   iss_valid,
    output logic [NSRC*DATA_W-1:0] iss_val,
    output logic [TAG_W-1:0]       iss_dst,
    output logic                   full
);
    localparam int TW = NSRC * TAG_W;
    localparam int VW = NSRC * DATA_W;

    occ_e state, nxt_state;
    int   cnt;

    // slot storage, slot 0 oldest
    logic [NSRC-1:0]  rdy_q [DEPTH];
    logic [TW-1:0]    tag_q [DEPTH];
    logic [VW-1:0]    val_q [DEPTH];
    logic [TAG_W-1:0] dst_q [DEPTH];

    logic [NSRC-1:0]  rdy_n [DEPTH];
    logic [TW-1:0]    tag_n [DEPTH];
    logic [VW-1:0]    val_n [DEPTH];
    logic [TAG_W-1:0] dst_n [DEPTH];

    // woken views
    logic [NSRC-1:0]  rdy_w [DEPTH];
    logic [VW-1:0]    val_w [DEPTH];
    logic [DEPTH-1:0] all_w;
    logic [NSRC-1:0]  d_rdy_w;
    logic [VW-1:0]    d_val_w;
    logic             d_all;

    logic [DEPTH-1:0] slot_ok;
    logic [DEPTH-1:0] gnt;
    logic             any_ok;
    int               pick;

    logic disp_ok, issue_slot, bypass, park;

    assign cnt = occ_count(state, DEPTH);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rs_wakeup #(.NSRC(NSRC), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_wake (
            .rdy_i(rdy_q[i]), .tag_i(tag_q[i]), .val_i(val_q[i]),
            .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
            .rdy_o(rdy_w[i]), .val_o(val_w[i]), .all_o(all_w[i])
        );
        assign slot_ok[i] = (i < cnt) && all_w[i];
    end

    rs_wakeup #(.NSRC(NSRC), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_wake_disp (
        .rdy_i(disp_rdy), .tag_i(disp_tag), .val_i(disp_val),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .rdy_o(d_rdy_w), .val_o(d_val_w), .all_o(d_all)
    );

    rs_oldest #(.DEPTH(DEPTH)) u_pick (
        .clk(clk), .rst_n(rst_n), .req(slot_ok), .gnt(gnt), .any(any_ok)
    );

    always_comb begin
        pick = 0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (gnt[i]) pick = i;
    end

    // output process
    always_comb begin
        issue_slot = unit_ready && any_ok && !flush;
        full       = (state == OCC_FULL) && !issue_slot;
        disp_ok    = disp_valid && !flush && !full;
        bypass     = disp_ok && d_all && unit_ready && !any_ok;
        park       = disp_ok && !bypass;
        iss_valid  = issue_slot || bypass;
        if (issue_slot) begin
            iss_val = val_w[pick];
            iss_dst = dst_q[pick];
        end else if (bypass) begin
            iss_val = d_val_w;
            iss_dst = disp_dst;
        end else begin
            iss_val = '0;
            iss_dst = '0;
        end
    end

    // next-slot contents: drop the issued slot, shift younger down, append
    always_comb begin
        int c1;
        int j;
        c1 = cnt - (issue_slot ? 1 : 0);
        for (int i = 0; i < DEPTH; i++) begin
            j = i;
            if (issue_slot && (i >= pick) && (i + 1 < DEPTH))
                j = i + 1;
            rdy_n[i] = rdy_w[j];
            tag_n[i] = tag_q[j];
            val_n[i] = val_w[j];
            dst_n[i] = dst_q[j];
            if (park && (i == c1)) begin
                rdy_n[i] = d_rdy_w;
                tag_n[i] = disp_tag;
                val_n[i] = d_val_w;
                dst_n[i] = disp_dst;
            end
        end
        // transitions: STAY, PARK, DRAIN, SWAP, CLEAR
        if (flush)
            nxt_state = OCC_EMPTY;
        else
            nxt_state = occ_state(c1 + (park ? 1 : 0), DEPTH);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= OCC_EMPTY;
        else
            state <= nxt_state;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            rdy_q[i] <= rdy_n[i];
            tag_q[i] <= tag_n[i];
            val_q[i] <= val_n[i];
            dst_q[i] <= dst_n[i];
        end
    end

    assert_issue_needs_unit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> unit_ready);

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state == OCC_EMPTY));

    assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !iss_valid);

    assert_drain_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !disp_valid && !flush) |=> (cnt == $past(cnt) - 1));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && disp_valid && !flush) |=> (cnt == $past(cnt)));

endmodule

// File: tb/tb_rs_station.sv
module tb_rs_station;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 2;
    localparam int NSRC   = 2;
    localparam int TAG_W  = 6;
    localparam int DATA_W = 32;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   flush;
    logic                   disp_valid;
    logic [NSRC-1:0]        disp_rdy;
    logic [NSRC*TAG_W-1:0]  disp_tag;
    logic [NSRC*DATA_W-1:0] disp_val;
    logic [TAG_W-1:0]       disp_dst;
    logic                   bc_valid;
    logic [TAG_W-1:0]       bc_tag;
    logic [DATA_W-1:0]      bc_val;
    logic                   unit_ready;
    logic                   iss_valid;
    logic [NSRC*DATA_W-1:0] iss_val;
    logic [TAG_W-1:0]       iss_dst;
    logic                   full;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rs_station #(.DEPTH(DEPTH), .NSRC(NSRC), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_rdy(disp_rdy), .disp_tag(disp_tag),
        .disp_val(disp_val), .disp_dst(disp_dst),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .unit_ready(unit_ready),
        .iss_valid(iss_valid), .iss_val(iss_val), .iss_dst(iss_dst), .full(full)
    );

    // next cycle: drive at the falling edge, settle, then sample
    task automatic cyc(input logic ur, input logic fl);
        @(negedge clk);
        disp_valid = 1'b0; bc_valid = 1'b0; unit_ready = ur; flush = fl;
    endtask

    task automatic disp(input logic [1:0] rdy, input logic [TAG_W-1:0] t0, t1,
                        input logic [DATA_W-1:0] v0, v1, input logic [TAG_W-1:0] dst);
        disp_valid = 1'b1; disp_rdy = rdy;
        disp_tag = {t1, t0}; disp_val = {v1, v0}; disp_dst = dst;
    endtask

    task automatic bcast(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] v);
        bc_valid = 1'b1; bc_tag = t; bc_val = v;
    endtask

    task automatic chk_full(input string req, input logic exp);
        #1;
        checks++;
        if (full !== exp) begin
            errors++;
            $display("FAIL %s full act %b exp %b", req, full, exp);
        end
    endtask

    task automatic chk_iss(input string req, input logic exp_v,
                           input logic [DATA_W-1:0] v0, v1, input logic [TAG_W-1:0] dst);
        #1;
        checks++;
        if (iss_valid !== exp_v) begin
            errors++;
            $display("FAIL %s iss_valid act %b exp %b", req, iss_valid, exp_v);
        end else if (exp_v && (iss_val !== {v1, v0} || iss_dst !== dst)) begin
            errors++;
            $display("FAIL %s issue act %h/%h exp %h/%h", req, iss_val, iss_dst,
                     {v1, v0}, dst);
        end
    endtask

    task automatic t_reset;
        chk_iss("R1", 1'b0, '0, '0, '0);
        chk_full("R1", 1'b0);
    endtask

    task automatic t_wakeup;
        cyc(1, 0); disp(2'b01, 6'd0, 6'd5, 32'h1111, 32'h0, 6'd3);
        chk_iss("R2", 1'b0, '0, '0, '0);
        cyc(1, 0); bcast(6'd7, 32'h7777);
        chk_iss("R3 nonmatching", 1'b0, '0, '0, '0);
        cyc(1, 0); bcast(6'd5, 32'hABCD);
        chk_iss("R3 same-cycle", 1'b1, 32'h1111, 32'hABCD, 6'd3);
        cyc(1, 0);
        chk_iss("R3 drained", 1'b0, '0, '0, '0);
    endtask

    task automatic t_ready_ignores;
        cyc(1, 0); disp(2'b01, 6'd9, 6'd9, 32'h2222, 32'h0, 6'd4);
        cyc(1, 0); bcast(6'd9, 32'h9999);
        chk_iss("R4", 1'b1, 32'h2222, 32'h9999, 6'd4);
    endtask

    task automatic t_bypass;
        cyc(1, 0); disp(2'b11, 6'd1, 6'd2, 32'hA0A0, 32'hB0B0, 6'd10);
        chk_iss("R5 bypass", 1'b1, 32'hA0A0, 32'hB0B0, 6'd10);
        cyc(1, 0);
        chk_iss("R5 not parked", 1'b0, '0, '0, '0);
    endtask

    task automatic t_busy;
        cyc(0, 0); disp(2'b11, 6'd1, 6'd2, 32'hC1, 32'hC2, 6'd11);
        chk_iss("R6 busy dispatch", 1'b0, '0, '0, '0);
        cyc(0, 0);
        chk_iss("R6 held", 1'b0, '0, '0, '0);
        cyc(1, 0);
        chk_iss("R6 release", 1'b1, 32'hC1, 32'hC2, 6'd11);
    endtask

    task automatic t_early_bcast;
        cyc(1, 0); disp(2'b00, 6'd4, 6'd6, 32'h0, 32'h0, 6'd12);
        bcast(6'd4, 32'h4444);
        chk_iss("R10 park", 1'b0, '0, '0, '0);
        cyc(1, 0); bcast(6'd6, 32'h6666);
        chk_iss("R10 captured", 1'b1, 32'h4444, 32'h6666, 6'd12);
    endtask

    task automatic t_full_order;
        cyc(0, 0); disp(2'b11, 6'd1, 6'd1, 32'h11, 32'h12, 6'd1);
        cyc(0, 0); disp(2'b11, 6'd1, 6'd1, 32'h21, 32'h22, 6'd2);
        cyc(0, 0); disp(2'b11, 6'd1, 6'd1, 32'h31, 32'h32, 6'd13);
        chk_full("R8 full", 1'b1);
        cyc(1, 0);
        chk_iss("R7 oldest", 1'b1, 32'h11, 32'h12, 6'd1);
        chk_full("R8 issuing", 1'b0);
        cyc(1, 0);
        chk_iss("R7 second", 1'b1, 32'h21, 32'h22, 6'd2);
        cyc(1, 0);
        chk_iss("R8 ignored", 1'b0, '0, '0, '0);
    endtask

    task automatic t_ready_order;
        cyc(1, 0); disp(2'b00, 6'd3, 6'd3, 32'h0, 32'h0, 6'd1);
        cyc(1, 0); disp(2'b10, 6'd12, 6'd0, 32'h0, 32'h5, 6'd2);
        cyc(1, 0); bcast(6'd12, 32'h55);
        chk_iss("R7 younger ready", 1'b1, 32'h55, 32'h5, 6'd2);
        cyc(1, 0); bcast(6'd3, 32'h33);
        chk_iss("R7 waiter", 1'b1, 32'h33, 32'h33, 6'd1);
        cyc(1, 0); disp(2'b00, 6'd3, 6'd3, 32'h0, 32'h0, 6'd1);
        cyc(1, 0); disp(2'b00, 6'd3, 6'd3, 32'h0, 32'h0, 6'd2);
        cyc(1, 0); bcast(6'd3, 32'h77);
        chk_iss("R7 both ready", 1'b1, 32'h77, 32'h77, 6'd1);
        cyc(1, 0);
        chk_iss("R7 then younger", 1'b1, 32'h77, 32'h77, 6'd2);
    endtask

    task automatic t_swap;
        cyc(0, 0); disp(2'b11, 6'd1, 6'd1, 32'hA1, 32'hA2, 6'd1);
        cyc(0, 0); disp(2'b11, 6'd1, 6'd1, 32'hB1, 32'hB2, 6'd2);
        cyc(1, 0); disp(2'b00, 6'd8, 6'd8, 32'h0, 32'h0, 6'd5);
        chk_full("R8 swap", 1'b0);
        chk_iss("R8 swap issue", 1'b1, 32'hA1, 32'hA2, 6'd1);
        cyc(1, 0);
        chk_iss("R8 swap next", 1'b1, 32'hB1, 32'hB2, 6'd2);
        cyc(1, 0); bcast(6'd8, 32'h88);
        chk_iss("R8 accepted", 1'b1, 32'h88, 32'h88, 6'd5);
    endtask

    task automatic t_flush;
        cyc(1, 0); disp(2'b00, 6'd11, 6'd11, 32'h0, 32'h0, 6'd6);
        cyc(1, 0); disp(2'b00, 6'd11, 6'd11, 32'h0, 32'h0, 6'd7);
        cyc(1, 1); bcast(6'd11, 32'hEE);
        disp(2'b11, 6'd1, 6'd1, 32'h1, 32'h1, 6'd9);
        chk_iss("R9 flush cycle", 1'b0, '0, '0, '0);
        cyc(1, 0); bcast(6'd11, 32'hEE);
        chk_iss("R9 emptied", 1'b0, '0, '0, '0);
        chk_full("R9 emptied", 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; flush = 1'b0; disp_valid = 1'b0; disp_rdy = '0;
        disp_tag = '0; disp_val = '0; disp_dst = '0; bc_valid = 1'b0;
        bc_tag = '0; bc_val = '0; unit_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wakeup();
        t_ready_ignores();
        t_bypass();
        t_busy();
        t_early_bcast();
        t_full_order();
        t_ready_order();
        t_swap();
        t_flush();
        cyc(1, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule